// File: doc/BRIEF.md
# Per-Warp Dual Register Scoreboard

This block records, for every warp resident on an issue slot, which architectural registers still wait for a result. Two separate pending structures are kept. The timed structure covers arithmetic results whose latency is fixed: a per-register countdown is loaded at issue and the pending bit drops by itself when it reaches zero. The event structure covers memory results whose latency is unknown: the pending bit stays set until the memory side reports that the data for that warp and register has been written.

An issue scheduler presents each instruction it issues with its warp, destination register, result class and an asynchronous-copy flag. The memory side returns completions as a warp and a register. Before issuing, the scheduler asks whether up to three source registers of one warp are free of both kinds of pending write and gets one combined ready flag back. Asynchronous copies bypass both structures so the warp can continue at once. The highest register index is a hardwired zero register and is never tracked.

Top module: `warp_scoreboard`

## Requirements
- R1: After reset no register of any warp is pending, every query returns ready and the error flag is low.
- R2: An issue with class code 0 (integer or fused multiply-add) makes the destination pending for exactly ALU_LAT (4) cycles counted from the capturing clock edge.
- R3: An issue with class code 1 (special function) makes the destination pending for exactly SFU_LAT (16) cycles counted from the capturing clock edge.
- R4: An issue with class code 2 (load or atomic) keeps the destination pending for any number of cycles until a completion for the same warp and register is captured; the register is ready from that edge on.
- R5: Pending state is kept per warp; a pending register never makes the same register number of another warp read as not ready.
- R6: An issue with the asynchronous-copy flag set, or with class code 3 (no destination), marks no register pending.
- R7: ready_o is high only when every source k whose enable bit q_use_i[k] is set has neither a timed nor an event pending bit; sources with a clear enable bit count as ready. Queries are combinational on the registered state.
- R8: When an issue targets a bit in the same cycle as its timed expiry or its completion, the new write wins; a timed countdown restarts with the latency of the new class.
- R9: The highest register index (NUM_REGS-1, 63 at defaults) is never marked pending and always reads as ready.
- R10: A completion for a register whose event bit is already clear changes no pending state and sets cpl_err_o, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | Issue strobe |
| iss_warp_i | input | WW | Issuing warp |
| iss_reg_i | input | RW | Destination register |
| iss_class_i | input | 2 | Result class: 0 arithmetic, 1 special function, 2 memory, 3 none |
| iss_async_i | input | 1 | Asynchronous copy, no register marked |
| cpl_valid_i | input | 1 | Memory completion strobe |
| cpl_warp_i | input | WW | Completing warp |
| cpl_reg_i | input | RW | Completing register |
| q_warp_i | input | WW | Queried warp |
| q_src0_i | input | RW | Source register 0 |
| q_src1_i | input | RW | Source register 1 |
| q_src2_i | input | RW | Source register 2 |
| q_use_i | input | 3 | Enable per source |
| ready_o | output | 1 | All enabled sources ready |
| cpl_err_o | output | 1 | Sticky spurious-completion flag |

## Verification
Every input is captured at one rising edge and its effect is visible on the combinational query right after that edge, so the bench drives on the falling edge and samples one falling edge later. A timed write must read busy on exactly ALU_LAT or SFU_LAT consecutive samples after the capturing edge and ready on the next, and the bench counts those samples instead of trusting a single point. An event write must read busy on every sample until the completion edge and ready on the first sample after it; the error flag is due on the sample right after a spurious completion.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_SFU  = 2'd1,
    CLS_MEM  = 2'd2,
    CLS_NONE = 2'd3
  } res_class_e;
endpackage

// File: rtl/sb_timed.sv
module sb_timed #(
  parameter int N   = 256,
  parameter int IW  = 8,
  parameter int CW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic [CW-1:0] set_lat_i,
  output logic [N-1:0]  pend_o
);
  for (genvar e = 0; e < N; e++) begin : g_ent
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cnt_q <= '0;
      else if (set_i && set_idx_i == IW'(e))     cnt_q <= set_lat_i;  // set beats expiry
      else if (cnt_q != '0)                      cnt_q <= cnt_q - 1'b1;
    end
    assign pend_o[e] = (cnt_q != '0);
  end
endmodule

// File: rtl/sb_event.sv
module sb_event #(
  parameter int N  = 256,
  parameter int IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic          clr_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  pend_o,
  output logic          err_o
);
  logic [N-1:0] bit_q;

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              bit_q[e] <= 1'b0;
      else if (set_i && set_idx_i == IW'(e))    bit_q[e] <= 1'b1;  // set beats completion
      else if (clr_i && clr_idx_i == IW'(e))    bit_q[e] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         err_o <= 1'b0;
    else if (clr_i && !bit_q[clr_idx_i]) err_o <= 1'b1;
  end

  assign pend_o = bit_q;
endmodule

// File: rtl/sb_query.sv
module sb_query #(
  parameter int N  = 256,
  parameter int WW = 2,
  parameter int RW = 6,
  parameter int NS = 3
) (
  input  logic [N-1:0]       short_pend_i,
  input  logic [N-1:0]       long_pend_i,
  input  logic [WW-1:0]      warp_i,
  input  logic [NS*RW-1:0]   src_i,
  input  logic [NS-1:0]      use_i,
  output logic               ready_o
);
  logic [N-1:0]  busy;
  logic [NS-1:0] src_ok;

  assign busy = short_pend_i | long_pend_i;

  for (genvar k = 0; k < NS; k++) begin : g_src
    logic [WW+RW-1:0] idx;
    assign idx       = {warp_i, src_i[k*RW +: RW]};
    assign src_ok[k] = !use_i[k] || !busy[idx];
  end

  assign ready_o = &src_ok;
endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 64,
  parameter int ALU_LAT   = 4,
  parameter int SFU_LAT   = 16,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iss_valid_i,
  input  logic [WW-1:0] iss_warp_i,
  input  logic [RW-1:0] iss_reg_i,
  input  logic [1:0]    iss_class_i,
  input  logic          iss_async_i,
  input  logic          cpl_valid_i,
  input  logic [WW-1:0] cpl_warp_i,
  input  logic [RW-1:0] cpl_reg_i,
  input  logic [WW-1:0] q_warp_i,
  input  logic [RW-1:0] q_src0_i,
  input  logic [RW-1:0] q_src1_i,
  input  logic [RW-1:0] q_src2_i,
  input  logic [2:0]    q_use_i,
  output logic          ready_o,
  output logic          cpl_err_o
);
  localparam int N        = NUM_WARPS * NUM_REGS;
  localparam int IW       = WW + RW;
  localparam int MAX_LAT  = (SFU_LAT > ALU_LAT) ? SFU_LAT : ALU_LAT;
  localparam int CW       = $clog2(MAX_LAT + 1);
  localparam logic [RW-1:0] ZERO_REG = RW'(NUM_REGS - 1);

  res_class_e    cls;
  logic          iss_write;
  logic          short_set;
  logic          long_set;
  logic [CW-1:0] short_lat;
  logic [IW-1:0] iss_idx;
  logic [IW-1:0] cpl_idx;
  logic [N-1:0]  short_pend;
  logic [N-1:0]  long_pend;

  assign cls       = res_class_e'(iss_class_i);
  assign iss_write = iss_valid_i && !iss_async_i && (iss_reg_i != ZERO_REG);
  assign short_set = iss_write && (cls == CLS_ALU || cls == CLS_SFU);
  assign long_set  = iss_write && (cls == CLS_MEM);
  assign short_lat = (cls == CLS_SFU) ? CW'(SFU_LAT) : CW'(ALU_LAT);
  assign iss_idx   = {iss_warp_i, iss_reg_i};
  assign cpl_idx   = {cpl_warp_i, cpl_reg_i};

  sb_timed #(.N(N), .IW(IW), .CW(CW)) u_timed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (short_set),
    .set_idx_i (iss_idx),
    .set_lat_i (short_lat),
    .pend_o    (short_pend)
  );

  sb_event #(.N(N), .IW(IW)) u_event (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (long_set),
    .set_idx_i (iss_idx),
    .clr_i     (cpl_valid_i),
    .clr_idx_i (cpl_idx),
    .pend_o    (long_pend),
    .err_o     (cpl_err_o)
  );

  sb_query #(.N(N), .WW(WW), .RW(RW), .NS(3)) u_query (
    .short_pend_i (short_pend),
    .long_pend_i  (long_pend),
    .warp_i       (q_warp_i),
    .src_i        ({q_src2_i, q_src1_i, q_src0_i}),
    .use_i        (q_use_i),
    .ready_o      (ready_o)
  );
endmodule

// File: rtl/warp_scoreboard_chk.sv
module warp_scoreboard_chk
  import sb_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 64,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS),
  localparam int N  = NUM_WARPS * NUM_REGS
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          iss_valid_i,
  input logic [WW-1:0] iss_warp_i,
  input logic [RW-1:0] iss_reg_i,
  input logic [1:0]    iss_class_i,
  input logic          iss_async_i,
  input logic          cpl_valid_i,
  input logic [RW-1:0] q_src0_i,
  input logic [RW-1:0] q_src1_i,
  input logic [RW-1:0] q_src2_i,
  input logic          ready_o,
  input logic          cpl_err_o,
  input logic [N-1:0]  short_pend,
  input logic [N-1:0]  long_pend
);
  localparam logic [RW-1:0] ZREG = RW'(NUM_REGS - 1);
  logic [WW+RW-1:0] idx;
  logic             real_iss;
  assign idx      = {iss_warp_i, iss_reg_i};
  assign real_iss = iss_valid_i && !iss_async_i && iss_reg_i != ZREG;

  p_timed_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    real_iss && (iss_class_i == CLS_ALU || iss_class_i == CLS_SFU) |=> short_pend[$past(idx)]);

  p_event_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    real_iss && iss_class_i == CLS_MEM |=> long_pend[$past(idx)]);

  p_event_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpl_valid_i |=> $countones(long_pend) >= $past($countones(long_pend)));

  p_async_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iss_valid_i || iss_async_i || iss_class_i == CLS_NONE) |=>
      $countones(short_pend) <= $past($countones(short_pend)));

  p_zero_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_src0_i == ZREG && q_src1_i == ZREG && q_src2_i == ZREG) |-> ready_o);

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_err_o |=> cpl_err_o);
endmodule

bind warp_scoreboard warp_scoreboard_chk #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_warp_i  (iss_warp_i),
  .iss_reg_i   (iss_reg_i),
  .iss_class_i (iss_class_i),
  .iss_async_i (iss_async_i),
  .cpl_valid_i (cpl_valid_i),
  .q_src0_i    (q_src0_i),
  .q_src1_i    (q_src1_i),
  .q_src2_i    (q_src2_i),
  .ready_o     (ready_o),
  .cpl_err_o   (cpl_err_o),
  .short_pend  (short_pend),
  .long_pend   (long_pend)
);

// File: tb/tb_warp_scoreboard.sv
module tb_warp_scoreboard;
  localparam int NW = 4;
  localparam int NR = 64;
  localparam int WW = 2;
  localparam int RW = 6;
  localparam int ALU_LAT = 4;
  localparam int SFU_LAT = 16;
  localparam int ZR = NR - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          iss_valid_i = 1'b0;
  logic [WW-1:0] iss_warp_i = '0;
  logic [RW-1:0] iss_reg_i = '0;
  logic [1:0]    iss_class_i = '0;
  logic          iss_async_i = 1'b0;
  logic          cpl_valid_i = 1'b0;
  logic [WW-1:0] cpl_warp_i = '0;
  logic [RW-1:0] cpl_reg_i = '0;
  logic [WW-1:0] q_warp_i = '0;
  logic [RW-1:0] q_src0_i = '0;
  logic [RW-1:0] q_src1_i = '0;
  logic [RW-1:0] q_src2_i = '0;
  logic [2:0]    q_use_i = '0;
  logic          ready_o;
  logic          cpl_err_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  warp_scoreboard dut (
    .clk_i, .rst_ni, .iss_valid_i, .iss_warp_i, .iss_reg_i, .iss_class_i, .iss_async_i,
    .cpl_valid_i, .cpl_warp_i, .cpl_reg_i, .q_warp_i, .q_src0_i, .q_src1_i, .q_src2_i,
    .q_use_i, .ready_o, .cpl_err_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at falling edge, return one falling edge later
  task automatic step(input bit iv, input int w, input int r, input int cls, input bit as,
                      input bit cv, input int cw, input int cr);
    iss_valid_i = iv; iss_warp_i = WW'(w); iss_reg_i = RW'(r);
    iss_class_i = 2'(cls); iss_async_i = as;
    cpl_valid_i = cv; cpl_warp_i = WW'(cw); cpl_reg_i = RW'(cr);
    @(negedge clk_i);
    iss_valid_i = 1'b0; cpl_valid_i = 1'b0; iss_async_i = 1'b0;
  endtask

  task automatic q3(input int w, input int s0, input int s1, input int s2, input int u,
                    output int rdy);
    q_warp_i = WW'(w); q_src0_i = RW'(s0); q_src1_i = RW'(s1); q_src2_i = RW'(s2);
    q_use_i = 3'(u);
    #1 rdy = int'(ready_o);
  endtask

  task automatic q1(input int w, input int r, output int rdy);
    q3(w, r, ZR, ZR, 1, rdy);
  endtask

  // count consecutive not-ready samples of (w,r)
  task automatic busy_len(input int w, input int r, output int len);
    int rdy;
    len = 0;
    for (int i = 0; i < 40; i++) begin
      q1(w, r, rdy);
      if (rdy == 1) break;
      len++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int rdy, len, bad;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    bad = 0;
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) begin
        q3(w, r, r, r, 7, rdy);
        if (rdy != 1) bad++;
      end
    chk("R1 reset all ready (not-ready count)", bad, 0);
    chk("R1 reset err", int'(cpl_err_o), 0);

    // R2 / R3 timed latencies across warps and registers
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR - 1; r += 13) begin
        step(1, w, r, 0, 0, 0, 0, 0);
        busy_len(w, r, len);
        chk($sformatf("R2 alu busy cycles w%0d r%0d", w, r), len, ALU_LAT);
        step(1, w, r, 1, 0, 0, 0, 0);
        busy_len(w, r, len);
        chk($sformatf("R3 sfu busy cycles w%0d r%0d", w, r), len, SFU_LAT);
      end

    // R4 / R5 / R9 sweep over every warp and register
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < NR; r++) begin
        step(1, w, r, 2, 0, 0, 0, 0);
        q1(w, r, rdy);
        if (r == ZR) chk($sformatf("R9 zero reg ready w%0d", w), rdy, 1);
        else         chk($sformatf("R4 mem pending w%0d r%0d", w, r), rdy, 0);
        q1((w + 1) % NW, r, rdy);
        chk($sformatf("R5 other warp ready w%0d r%0d", w, r), rdy, 1);
        if (r != ZR) begin
          step(0, 0, 0, 0, 0, 1, w, r);
          q1(w, r, rdy);
          chk($sformatf("R4 ready after completion w%0d r%0d", w, r), rdy, 1);
        end
      end
    // R9 timed class to zero reg
    step(1, 2, ZR, 1, 0, 0, 0, 0);
    q1(2, ZR, rdy);
    chk("R9 sfu to zero reg ready", rdy, 1);

    // R4 long hold
    step(1, 1, 20, 2, 0, 0, 0, 0);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      q1(1, 20, rdy);
      if (rdy != 0) bad++;
      @(negedge clk_i);
    end
    chk("R4 held 60 cycles (ready samples)", bad, 0);
    step(0, 0, 0, 0, 0, 1, 1, 20);
    q1(1, 20, rdy);
    chk("R4 cleared after long wait", rdy, 1);

    // R6 async and class none
    step(1, 0, 8, 2, 1, 0, 0, 0);
    q1(0, 8, rdy);
    chk("R6 async mem no pending", rdy, 1);
    step(1, 0, 9, 1, 1, 0, 0, 0);
    q1(0, 9, rdy);
    chk("R6 async sfu no pending", rdy, 1);
    step(1, 0, 10, 3, 0, 0, 0, 0);
    q1(0, 10, rdy);
    chk("R6 class none no pending", rdy, 1);

    // R7 multi-source combine
    step(1, 3, 10, 2, 0, 0, 0, 0);
    step(1, 3, 11, 1, 0, 0, 0, 0);
    q3(3, 1, 10, 2, 7, rdy);  chk("R7 src1 mem pending", rdy, 0);
    q3(3, 1, 10, 2, 5, rdy);  chk("R7 src1 disabled", rdy, 1);
    q3(3, 2, 1, 11, 4, rdy);  chk("R7 src2 sfu pending", rdy, 0);
    q3(3, 2, 1, 11, 3, rdy);  chk("R7 src2 disabled", rdy, 1);
    q3(3, 10, 1, 2, 1, rdy);  chk("R7 src0 pending", rdy, 0);
    q3(3, 1, 2, 3, 7, rdy);   chk("R7 all clear", rdy, 1);
    q3(3, 10, 11, 12, 0, rdy); chk("R7 no source enabled", rdy, 1);
    step(0, 0, 0, 0, 0, 1, 3, 10);
    repeat (SFU_LAT) @(negedge clk_i);

    // R8 set wins over timed expiry, latency restarts
    step(1, 1, 5, 0, 0, 0, 0, 0);
    repeat (ALU_LAT - 1) @(negedge clk_i);
    q1(1, 5, rdy);
    chk("R8 still pending on last cycle", rdy, 0);
    step(1, 1, 5, 1, 0, 0, 0, 0);
    busy_len(1, 5, len);
    chk("R8 reissue restarts at sfu latency", len, SFU_LAT);
    // R8 set wins over completion
    step(1, 2, 7, 2, 0, 0, 0, 0);
    step(1, 2, 7, 2, 0, 1, 2, 7);
    q1(2, 7, rdy);
    chk("R8 set beats completion", rdy, 0);
    chk("R8 no error on same-cycle set", int'(cpl_err_o), 0);
    step(0, 0, 0, 0, 0, 1, 2, 7);
    q1(2, 7, rdy);
    chk("R8 later completion clears", rdy, 1);

    // R10 spurious completion
    step(1, 3, 9, 2, 0, 0, 0, 0);
    chk("R10 err low before", int'(cpl_err_o), 0);
    step(0, 0, 0, 0, 0, 1, 0, 3);
    chk("R10 err set", int'(cpl_err_o), 1);
    q1(0, 3, rdy);
    chk("R10 target unchanged", rdy, 1);
    q1(3, 9, rdy);
    chk("R10 other pending kept", rdy, 0);
    step(0, 0, 0, 0, 0, 1, 3, 9);
    step(1, 0, 4, 0, 0, 0, 0, 0);
    repeat (20) @(negedge clk_i);
    chk("R10 err sticky", int'(cpl_err_o), 1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 R1 err cleared by reset", int'(cpl_err_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule